// File: doc/BRIEF.md
# Register-Loaded Serial Shift Engine

This block runs one single-lane serial flash transaction at a time from a small bank of byte registers. Software writes up to six outgoing bytes and a total bit count. It then sets the start bit in the control register. The engine pulls chip select low and clocks out exactly the requested number of bits. At the same moment it shifts every sampled input bit into a ten-byte receive history. The history can be read back afterwards.

The bit count is free-form up to the limit and need not be a whole number of bytes. A transaction can therefore carry one extra dummy clock when a flash needs it before its data. Command, address, dummy and data phases all use the one data line. The host sees the engine's progress through the busy bit in the control register, the `busy` pin and a one-cycle `done` pulse.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` is 0, and all ten receive bytes (addresses 8 to 17) read 0.
- R2: Address 6 holds the bit count. A written value above 56 is stored as 56, and any other value is stored as written. The register reads back what was stored.
- R3: Writing a 1 to bit 0 of address 7 starts a transaction when the engine is idle and the bit count is nonzero. While the transaction runs, bit 0 of address 7 and `busy` both read 1. When the bit count is 0, the start write produces no clock at all.
- R4: A transaction produces exactly as many `spi_sclk` pulses as the bit count. The clock idles low, and each level lasts `SCLK_HALF` system clocks. `spi_mosi` changes only after a falling edge, and `spi_cs_n` stays low for the whole transaction.
- R5: Outgoing bits come from the transmit bytes at addresses 5 down to 0, in that order, each byte sent MSB first. Any clocks after the 48th bit drive `spi_mosi` to 0.
- R6: On each rising `spi_sclk`, the `spi_miso` level is shifted into an 80-bit history. The byte at address 8+k holds history bits [8k+7:8k], so address 8 holds the newest eight bits. The history is not cleared between transactions.
- R7: In the system clock cycle after the last falling `spi_sclk` edge, `spi_cs_n` returns to 1, `busy` falls to 0, and `done` is 1 for exactly one cycle.
- R8: A start write that arrives while a transaction is running is ignored. The running transaction keeps its original bit count.
- R9: Bit counts that are not a multiple of 8 are supported. The receive bytes then span byte boundaries as R6 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational register read data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with `SCLK_HALF` set to 3, so each serial clock level spans several system cycles. This exposes any off-by-one in the divider and leaves room to issue a start write in the middle of a transaction. The byte counts and the 56-bit limit keep their default values. A 56-bit run therefore crosses the point where the transmit bytes run out, and the ten-byte history only fills across several transactions. That makes the carry-over of older bytes visible. Odd counts of 1 and 17 bits cover transactions that end partway through a byte.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int SCLK_HALF = 2,
  parameter int TX_BYTES  = 6,
  parameter int RX_BYTES  = 10,
  parameter int MAX_BITS  = 56,
  parameter int AW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          busy,
  output logic          done,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int TXW = TX_BYTES * 8;
  localparam int RXW = RX_BYTES * 8;
  localparam int CW  = $clog2(MAX_BITS + 1);
  localparam int DW  = $clog2(SCLK_HALF + 1);
  localparam logic [AW-1:0] CNT_ADDR = AW'(TX_BYTES);
  localparam logic [AW-1:0] CTL_ADDR = AW'(TX_BYTES + 1);
  localparam logic [AW-1:0] RX_BASE  = AW'(TX_BYTES + 2);
  localparam logic [AW-1:0] RX_END   = AW'(TX_BYTES + 2 + RX_BYTES);

  typedef enum logic [1:0] {IDLE, SHIFT, LAST} st_t;

  st_t           st_q;
  logic [TXW-1:0] tx_q, tx_sh;
  logic [RXW-1:0] rx_q;
  logic [CW-1:0]  cnt_q, left_q;
  logic [DW-1:0]  div_q;
  logic           sclk_q, done_q;

  logic [AW-1:0] ridx;
  logic [AW+2:0] tsel, rsel;
  assign ridx = reg_addr - RX_BASE;
  assign tsel = {reg_addr, 3'b000};
  assign rsel = {ridx, 3'b000};

  logic start_w, tick;
  assign busy     = (st_q != IDLE);
  assign start_w  = reg_we && reg_addr == CTL_ADDR && reg_wdata[0] && !busy && cnt_q != '0;
  assign tick     = (div_q == DW'(SCLK_HALF - 1));
  assign spi_sclk = sclk_q;
  assign spi_cs_n = !busy;
  assign spi_mosi = tx_sh[TXW-1];
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      cnt_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr < CNT_ADDR)
        tx_q[tsel +: 8] <= reg_wdata;
      else if (reg_addr == CNT_ADDR)
        cnt_q <= (int'(reg_wdata) > MAX_BITS) ? CW'(MAX_BITS) : reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      tx_sh  <= '0;
      rx_q   <= '0;
      left_q <= '0;
      div_q  <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        IDLE: if (start_w) begin
          st_q   <= SHIFT;
          tx_sh  <= tx_q;
          left_q <= cnt_q;
          div_q  <= '0;
          sclk_q <= 1'b0;
        end
        SHIFT: if (tick) begin
          div_q  <= '0;
          sclk_q <= !sclk_q;
          if (!sclk_q) begin
            rx_q <= {rx_q[RXW-2:0], spi_miso};
          end else begin
            tx_sh <= {tx_sh[TXW-2:0], 1'b0};
            if (left_q == CW'(1)) st_q <= LAST;
            else left_q <= left_q - 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
        default: begin
          st_q   <= IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < CNT_ADDR)
      reg_rdata = tx_q[tsel +: 8];
    else if (reg_addr == CNT_ADDR)
      reg_rdata = 8'(cnt_q);
    else if (reg_addr == CTL_ADDR)
      reg_rdata = {7'b0, busy};
    else if (reg_addr >= RX_BASE && reg_addr < RX_END)
      reg_rdata = rx_q[rsel +: 8];
  end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int MAX_BITS = 56,
  parameter int CW       = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sclk,
  input logic          cs_n,
  input logic          mosi,
  input logic [CW-1:0] cnt
);
  // R4
  frame_select_chk: assert property (@(posedge clk) disable iff (!rst_n) busy == !cs_n);
  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) int'(cnt) <= MAX_BITS);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.MAX_BITS(MAX_BITS), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sclk(spi_sclk),
  .cs_n(spi_cs_n), .mosi(spi_mosi), .cnt(cnt_q)
);

// File: tb/spi_shift_engine_tb_top.sv
module spi_shift_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic busy, done, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  spi_shift_engine #(.SCLK_HALF(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0, failed = 0, sclk_cnt = 0;
  bit exp_q[$];
  logic [79:0] hist_exp = '0;
  logic [7:0] lfsr = 8'hB7;
  assign spi_miso = lfsr[0];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge spi_sclk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  // monitor: pops expected mosi bits and tracks received history
  always @(posedge spi_sclk) begin
    sclk_cnt++;
    hist_exp = {hist_exp[78:0], spi_miso};
    if (exp_q.size() == 0) chk(0, "R4 extra clock", 1, 0);
    else begin
      bit e;
      e = exp_q.pop_front();
      chk(spi_mosi == e, "R5 mosi bit", spi_mosi, e);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    while (done !== 1'b1) @(negedge clk);
    chk(spi_cs_n == 1 && busy == 0, {tag, " R7 end state"}, {spi_cs_n, busy}, 2'b10);
    @(negedge clk);
    chk(done == 0, {tag, " R7 done one cycle"}, done, 0);
  endtask

  task automatic check_rx(input string tag);
    logic [7:0] v;
    for (int k = 0; k < 10; k++) begin
      rd(5'(8 + k), v);
      chk(v == hist_exp[8*k +: 8], {tag, " R6 rx byte"}, v, hist_exp[8*k +: 8]);
    end
  endtask

  // driver: loads registers and pushes the expected bit stream
  task automatic run_txn(input logic [47:0] tx, input int n, input bit poke, input string tag);
    logic [7:0] v;
    int base;
    for (int k = 0; k < 6; k++) wr(5'(k), tx[8*k +: 8]);
    wr(5'd6, 8'(n));
    for (int i = 0; i < n; i++) exp_q.push_back(i < 48 ? tx[47 - i] : 1'b0);
    base = sclk_cnt;
    wr(5'd7, 8'h01);
    rd(5'd7, v);
    chk(v[0] == 1 && busy == 1, {tag, " R3 busy readback"}, v, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      wr(5'd7, 8'h01);
    end
    wait_done(tag);
    chk(sclk_cnt - base == n, {tag, " R4 clock count"}, sclk_cnt - base, n);
    chk(exp_q.size() == 0, {tag, " R5 bits left"}, exp_q.size(), 0);
    check_rx(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && spi_sclk == 0 && busy == 0, "R1 reset pins", {spi_cs_n, spi_sclk, busy}, 3'b100);
    rst_n = 1;
    check_rx("R1 reset");
    // R2 saturation and readback
    wr(5'd6, 8'd63); rd(5'd6, v);
    chk(v == 56, "R2 clamp", v, 56);
    wr(5'd6, 8'd33); rd(5'd6, v);
    chk(v == 33, "R2 readback", v, 33);
    // R3 zero count makes no clock
    wr(5'd6, 8'd0);
    base = sclk_cnt;
    wr(5'd7, 8'h01);
    repeat (20) @(negedge clk);
    chk(sclk_cnt == base && busy == 0, "R3 zero count", sclk_cnt - base, 0);
    run_txn(48'hA5_00_00_00_00_00, 8, 0, "R5 byte8");
    run_txn(48'h9F_12_34_56_78_C3, 56, 0, "R5 full56");
    run_txn(48'h0B_FF_01_80_7E_55, 17, 0, "R9 odd17");
    run_txn(48'h80_00_00_00_00_00, 1, 0, "R9 one");
    run_txn(48'hC0_FF_EE_12_34_56, 24, 1, "R8 restart");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule